// File: doc/BRIEF.md
# Masked 24-Source Interrupt Aggregator

This block gathers 24 event inputs from a power-management device into one active-high interrupt request. Each event input is edge-detected. Its rising edge sets a sticky status bit, unless a latch-enable mask blocks it. A second mask decides which of the latched bits may raise the shared interrupt pin. The 24 status bits sit in three byte registers. Byte 0 holds sources 0–7, byte 1 holds sources 8–15 and byte 2 holds sources 16–23. Two reserved positions (12 and 23) never latch.

A host reaches the nine byte registers over a small byte-wide command channel. Each register group takes three consecutive addresses: the line masks at 0x00–0x02, the latch masks at 0x03–0x05 and the status bytes at 0x06–0x08. A command with `cmd_first` high uses `cmd_addr`. A command with `cmd_first` low uses the address after the previous accepted command, which gives auto-incrementing bursts. The channel follows valid/ready rules: a command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is always high, so the block never applies back-pressure. A read returns one `rsp_valid` pulse one cycle after it is accepted, and the response has no back-pressure.

A write of any value to any status address clears all 24 status bits. The usual service routine is therefore: burst-read the three status bytes, handle the sources, then perform one clearing write.

Top module: `irqagg_top`

## Requirements
- R1: After reset every line-mask and latch-mask bit reads 1, every status bit reads 0, and `irq_out` is low.
- R2: A rising edge on a source whose latch-mask bit is 0 sets its status bit, visible from the next cycle. The bit stays set while the source stays high or falls, until a clearing write.
- R3: While a source's latch-mask bit is 1, its edges do not change its status bit.
- R4: Any accepted write to address 0x06, 0x07 or 0x08 clears all 24 status bits, whatever data is written. A qualifying edge in the same cycle as the clear still sets its bit.
- R5: `irq_out` is a register. It is high exactly when, in the previous cycle, some status bit was 1 while its line-mask bit was 0.
- R6: Status positions 12 and 23 never set and always read 0.
- R7: A command with `cmd_first` low uses the previous accepted command's address plus one. A burst read that starts at 0x06 returns status bytes 0, 1 and 2 in that order.
- R8: Mask registers are read/write. A read returns the last value written, and a three-byte burst write programs a whole group. A mask bit of 1 disables a source and 0 enables it.
- R9: Reads of any address above 0x08 return 0, and writes to those addresses change no register.
- R10: `cmd_ready` is always 1. An accepted read produces `rsp_valid` high for exactly one cycle, on the next cycle, with data taken before that edge's updates. No other cycle has `rsp_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 24 | Event source inputs, bit i is source i |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command ready (always 1) |
| cmd_first | input | 1 | 1: use cmd_addr; 0: previous address plus one |
| cmd_addr | input | 8 | Register address when cmd_first is 1 |
| cmd_we | input | 1 | 1 write, 0 read |
| cmd_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 8 | Read data |
| irq_out | output | 1 | Registered aggregated interrupt |

## Verification
On every cycle, the assertions check four things: the registered interrupt tracks the previous cycle's unmasked status, a clear with no coincident edge empties the status, masked sources never gain a status bit, and read responses pulse exactly once per accepted read. Only the bench's scenarios can show the following: the address map, auto-increment across bursts, write data being ignored on a clear, the reserved positions reading 0, unmapped addresses leaving every register intact, and the edge-versus-clear priority. The bench checks these against a behavioural model, and against hand-worked values after each step.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int GRP_BYTES = 3;
  localparam int BYTE_W    = 8;
  localparam int NSRC      = GRP_BYTES * BYTE_W;

  typedef enum logic [1:0] {
    GRP_NONE  = 2'd0,
    GRP_LMASK = 2'd1,
    GRP_SMASK = 2'd2,
    GRP_STAT  = 2'd3
  } grp_e;
endpackage

// File: rtl/irqagg_latch.sv
module irqagg_latch
  import irqagg_pkg::*;
#(
  parameter int          N    = NSRC,
  parameter logic [N-1:0] RSVD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_in,
  input  logic [N-1:0] smask,
  input  logic         clr_all,
  output logic [N-1:0] set_vec,
  output logic [N-1:0] stat
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= evt_in;
  end

  assign rise    = evt_in & ~prev_q;
  assign set_vec = rise & ~smask & ~RSVD;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (RSVD[i]) begin : g_rsvd
      assign stat[i] = 1'b0;
    end else begin : g_live
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          bit_q <= 1'b0;
        else if (set_vec[i]) bit_q <= 1'b1;
        else if (clr_all)    bit_q <= 1'b0;
      end
      assign stat[i] = bit_q;
    end
  end
endmodule

// File: rtl/irqagg_regbus.sv
module irqagg_regbus
  import irqagg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LMASK_BASE = 0,
  parameter int SMASK_BASE = 3,
  parameter int STAT_BASE  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_first,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_we,
  input  logic [BYTE_W-1:0] cmd_wdata,
  input  logic [NSRC-1:0]   stat,
  output logic [NSRC-1:0]   lmask,
  output logic [NSRC-1:0]   smask,
  output logic              clr_all,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data
);
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] addr;
  logic              acc_wr;
  logic              acc_rd;
  grp_e              grp;
  logic [1:0]        idx;
  logic [BYTE_W-1:0] rd_byte;

  assign addr   = cmd_first ? cmd_addr : ptr_q;
  assign acc_wr = cmd_valid & cmd_we;
  assign acc_rd = cmd_valid & ~cmd_we;

  always_comb begin
    grp = GRP_NONE;
    idx = '0;
    for (int b = 0; b < GRP_BYTES; b++) begin
      if (addr == ADDR_W'(LMASK_BASE + b)) begin grp = GRP_LMASK; idx = 2'(b); end
      if (addr == ADDR_W'(SMASK_BASE + b)) begin grp = GRP_SMASK; idx = 2'(b); end
      if (addr == ADDR_W'(STAT_BASE + b))  begin grp = GRP_STAT;  idx = 2'(b); end
    end
  end

  assign clr_all = acc_wr && (grp == GRP_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (cmd_valid) ptr_q <= addr + ADDR_W'(1);
  end

  for (genvar b = 0; b < GRP_BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lmask[b*BYTE_W +: BYTE_W] <= '1;
        smask[b*BYTE_W +: BYTE_W] <= '1;
      end else if (acc_wr && idx == 2'(b)) begin
        if (grp == GRP_LMASK) lmask[b*BYTE_W +: BYTE_W] <= cmd_wdata;
        if (grp == GRP_SMASK) smask[b*BYTE_W +: BYTE_W] <= cmd_wdata;
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < GRP_BYTES; b++) begin
      if (idx == 2'(b)) begin
        case (grp)
          GRP_LMASK: rd_byte = lmask[b*BYTE_W +: BYTE_W];
          GRP_SMASK: rd_byte = smask[b*BYTE_W +: BYTE_W];
          GRP_STAT:  rd_byte = stat[b*BYTE_W +: BYTE_W];
          default:   rd_byte = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc_rd;
      if (acc_rd) rsp_data <= rd_byte;
    end
  end
endmodule

// File: rtl/irqagg_irqout.sv
module irqagg_irqout #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat,
  input  logic [N-1:0] lmask,
  output logic         irq_out
);
  logic [N-1:0] live;
  assign live = stat & ~lmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |live;
  end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int             ADDR_W     = 8,
  parameter int             LMASK_BASE = 0,
  parameter int             SMASK_BASE = 3,
  parameter int             STAT_BASE  = 6,
  parameter logic [NSRC-1:0] RSVD_MASK = 24'h80_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_in,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_first,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_we,
  input  logic [BYTE_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              irq_out
);
  logic [NSRC-1:0] stat_w;
  logic [NSRC-1:0] lmask_w;
  logic [NSRC-1:0] smask_w;
  logic [NSRC-1:0] set_w;
  logic            clr_w;

  assign cmd_ready = 1'b1;

  irqagg_regbus #(
    .ADDR_W(ADDR_W), .LMASK_BASE(LMASK_BASE),
    .SMASK_BASE(SMASK_BASE), .STAT_BASE(STAT_BASE)
  ) u_bus (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_first(cmd_first), .cmd_addr(cmd_addr),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .stat(stat_w),
    .lmask(lmask_w), .smask(smask_w), .clr_all(clr_w),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  irqagg_latch #(.N(NSRC), .RSVD(RSVD_MASK)) u_latch (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .smask(smask_w),
    .clr_all(clr_w), .set_vec(set_w), .stat(stat_w)
  );

  irqagg_irqout #(.N(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .stat(stat_w), .lmask(lmask_w), .irq_out(irq_out)
  );
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int N = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic         cmd_we,
  input logic         rsp_valid,
  input logic         irq_out,
  input logic [N-1:0] stat,
  input logic [N-1:0] lmask,
  input logic [N-1:0] smask,
  input logic [N-1:0] set_vec,
  input logic         clr_all
);
  a_r5_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & ~lmask)) |=> irq_out);

  a_r5_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat & ~lmask)) |=> !irq_out);

  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && set_vec == '0) |=> (stat == '0));

  a_r3_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat & ~$past(stat) & $past(smask)) == '0));

  a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_we) |=> rsp_valid);

  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && !cmd_we) |=> !rsp_valid);
endmodule

bind irqagg_top irqagg_chk #(.N(irqagg_pkg::NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_we(cmd_we),
  .rsp_valid(rsp_valid), .irq_out(irq_out), .stat(stat_w), .lmask(lmask_w),
  .smask(smask_w), .set_vec(set_w), .clr_all(clr_w)
);

// File: tb/sim_irqagg_top.sv
module sim_irqagg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] evt_in = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_first = 1'b0;
  logic [7:0]  cmd_addr = '0;
  logic        cmd_we = 1'b0;
  logic [7:0]  cmd_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        irq_out;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  irqagg_top u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_first(cmd_first), .cmd_addr(cmd_addr),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .irq_out(irq_out)
  );

  // Behavioural reference model
  logic [23:0] m_stat, m_lm, m_sm, m_prev;
  logic        m_irq, m_rv;
  logic [7:0]  m_rd;
  int          m_ptr;
  localparam logic [23:0] RSV = 24'h80_1000;

  function automatic logic [7:0] mread(int a);
    if (a < 3)      return m_lm[a*8 +: 8];
    else if (a < 6) return m_sm[(a-3)*8 +: 8];
    else if (a < 9) return m_stat[(a-6)*8 +: 8];
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = '0; m_lm = '1; m_sm = '1; m_prev = '0;
      m_irq = 0; m_rv = 0; m_rd = '0; m_ptr = 0;
    end else begin
      int a;
      logic [23:0] newb;
      a    = cmd_first ? int'(cmd_addr) : m_ptr;
      newb = evt_in & ~m_prev & ~m_sm & ~RSV;
      m_irq = |(m_stat & ~m_lm);
      m_rv  = cmd_valid && !cmd_we;
      if (m_rv) m_rd = mread(a);
      if (cmd_valid && cmd_we && a >= 6 && a < 9) m_stat = newb;
      else m_stat = m_stat | newb;
      if (cmd_valid && cmd_we && a < 3) m_lm[a*8 +: 8] = cmd_wdata;
      if (cmd_valid && cmd_we && a >= 3 && a < 6) m_sm[(a-3)*8 +: 8] = cmd_wdata;
      m_prev = evt_in;
      if (cmd_valid) m_ptr = (a + 1) % 256;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 irq vs model", int'(irq_out), int'(m_irq));
      chk("R10 rsp_valid vs model", int'(rsp_valid), int'(m_rv));
      if (m_rv) chk("R7 rsp_data vs model", int'(rsp_data), int'(m_rd));
      chk("R10 ready", int'(cmd_ready), 1);
    end
  end

  // tasks start and end at a falling edge
  task automatic wr(int a, int d, bit first);
    cmd_valid = 1; cmd_we = 1; cmd_first = first;
    cmd_addr = 8'(a); cmd_wdata = 8'(d);
    @(negedge clk);
    cmd_valid = 0; cmd_we = 0; cmd_first = 0;
  endtask

  task automatic rd(int a, bit first, int exp, string tag);
    cmd_valid = 1; cmd_we = 0; cmd_first = first; cmd_addr = 8'(a);
    @(negedge clk);
    cmd_valid = 0; cmd_first = 0;
    chk({tag, " rsp_valid"}, int'(rsp_valid), 1);
    chk(tag, int'(rsp_data), exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=<100000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    idle(2);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk("R1 irq low", int'(irq_out), 0);
    rd(0, 1, 8'hFF, "R1 lmask0");
    rd(0, 0, 8'hFF, "R1 lmask1");
    rd(0, 0, 8'hFF, "R1 lmask2");
    rd(3, 1, 8'hFF, "R1 smask0");
    rd(6, 1, 8'h00, "R1 stat0");
    // R3 all masked: pulse every source
    evt_in = '1; idle(1); evt_in = '0; idle(2);
    rd(6, 1, 8'h00, "R3 stat0 masked");
    rd(0, 0, 8'h00, "R3 stat1 masked");
    rd(0, 0, 8'h00, "R3 stat2 masked");
    chk("R3 irq low", int'(irq_out), 0);
    // R8 burst write of latch masks, R7 auto-increment
    wr(3, 8'h00, 1); wr(0, 8'h00, 0); wr(0, 8'h00, 0);
    rd(3, 1, 8'h00, "R8 smask0");
    rd(0, 0, 8'h00, "R8 smask1");
    rd(0, 0, 8'h00, "R8 smask2");
    rd(0, 1, 8'hFF, "R8 lmask untouched");
    // R2/R6: edges on 0, 12, 17, 23
    evt_in = 24'h82_1001; idle(2);
    rd(6, 1, 8'h01, "R2 stat byte0");
    rd(0, 0, 8'h00, "R6 stat byte1 bit12");
    rd(0, 0, 8'h02, "R6 stat byte2 bit23");
    chk("R5 irq low all lmasked", int'(irq_out), 0);
    // R5 unmask source 17 (byte2 bit1)
    wr(2, 8'hFD, 1);
    chk("R5 irq one cycle lag", int'(irq_out), 0);
    idle(1);
    chk("R5 irq high", int'(irq_out), 1);
    rd(2, 1, 8'hFD, "R8 lmask2 readback");
    // R2 sticky after source falls
    evt_in = '0; idle(2);
    rd(8, 1, 8'h02, "R2 sticky after fall");
    // R4 clear via byte1 with arbitrary data
    wr(7, 8'hAB, 1);
    idle(1);
    rd(6, 1, 8'h00, "R4 cleared byte0");
    rd(0, 0, 8'h00, "R4 cleared byte1");
    rd(0, 0, 8'h00, "R4 cleared byte2");
    chk("R5 irq low after clear", int'(irq_out), 0);
    // R4 edge coincides with clear: edge wins
    evt_in = 24'h00_0001; idle(2);
    evt_in = 24'h00_0021;
    wr(8, 8'h00, 1);
    rd(6, 1, 8'h20, "R4 edge beats clear");
    // R9 unmapped
    wr(8'h20, 8'h55, 1);
    rd(8'h20, 1, 8'h00, "R9 unmapped read");
    rd(9, 1, 8'h00, "R9 addr 9 read");
    rd(0, 1, 8'hFF, "R9 lmask0 intact");
    rd(4, 1, 8'h00, "R9 smask1 intact");
    rd(8, 1, 8'h00, "R9 stat2 intact");
    // R3 re-mask all and pulse
    wr(3, 8'hFF, 1); wr(0, 8'hFF, 0); wr(0, 8'hFF, 0);
    evt_in = '0; idle(1); evt_in = 24'h7F_EFFF; idle(1); evt_in = '0; idle(1);
    rd(6, 1, 8'h20, "R3 byte0 unchanged");
    rd(0, 0, 8'h00, "R3 byte1 unchanged");
    rd(0, 0, 8'h00, "R3 byte2 unchanged");
    idle(3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule